// File: doc/BRIEF.md
# Latched Push-Pull PWM Controller

This block is a fully digital pulse-width modulator for push-pull power stages. A counter ramp runs from zero up to a programmable period. Each period opens with a blanking interval of programmable length, during which both drive outputs are forced inactive. After blanking, a pulse stays active while the ramp is below the effective duty value. The effective duty value is the smaller of the duty command and a soft-start level. A steering flip-flop hands consecutive periods to output A and output B in turn, so each output can drive at most every other period. A termination latch ends a pulse for good once it has stopped, so no second pulse can appear within the same period.

Two control inputs act on the ramp and the pulses. An external sync input restarts the ramp, which lets several controllers follow one system clock. A shutdown input kills the running pulse at once and, if held, drains the soft-start level. After release, turn-on is therefore slow again. An undervoltage lockout uses two comparator flags with a hysteresis band between them. While locked out, both outputs stay inactive and soft-start is held at zero.

A parameter selects the idle level of the outputs: either idle low with active high, or idle high with active low.

Top module: `pwm_pushpull`

## Requirements
- R1: Once a pulse has ended (ramp reached the effective duty, shutdown or lockout), neither output drives again until the next period restart, even if the cause goes away.
- R2: Output A and output B are never active together. The steering flips on every period restart that happens outside blanking, so pulses alternate A, B, A, and the first period after reset belongs to A.
- R3: The ramp counts 0 to PERIOD-1. Counts 0 to DEAD-1 are blanking with both outputs inactive. A pulse is active for counts c with DEAD <= c < min(DUTY, PERIOD), which gives min(DUTY, PERIOD)-DEAD cycles per period when that number is positive.
- R4: A duty command at or below DEAD gives no pulses at all. The widest pulse is PERIOD-DEAD cycles per 2*PERIOD, so each output stays below 50% duty.
- R5: Shutdown passes through a two-stage synchronizer. Two clocks after shutdown_i rises, both outputs go inactive, and they stay inactive for as long as it is held.
- R6: The effective duty is min(DUTY, soft-start level). The soft-start level falls by 1 per clock under shutdown. Otherwise it rises by SS_STEP every SS_DIV period restarts and saturates at 2^CW-1. A one-cycle shutdown leaves later pulse widths unchanged. A long shutdown restarts the ramp-up, so the first periods after release are narrower.
- R7: Lockout is set at reset and whenever uv_low_i is 1. It is cleared only by uv_ok_i, and it holds its value while both flags are 0. While locked, both outputs are inactive and soft-start is zero.
- R8: With IDLE_HIGH = 0 the outputs are high when active and low when idle. With IDLE_HIGH = 1 each output is the exact inverse.
- R9: A rising edge on sync_i, after two synchronizer stages and an edge detector, restarts the ramp at 0. Syncing faster than PERIOD therefore shortens every period.
- R10: A sync edge that arrives while the ramp is in blanking restarts the ramp without flipping the steering. The period that follows belongs to the same output as the one the natural wrap just selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| period_i | input | CW | Ramp length in clocks (at least 2, greater than dead_i) |
| dead_i | input | CW | Blanking length in clocks at the start of each period |
| duty_i | input | CW | Duty command compared against the ramp |
| sync_i | input | 1 | External sync; rising edge restarts the ramp |
| shdn_i | input | 1 | Shutdown request |
| uv_low_i | input | 1 | Supply below the lower lockout threshold |
| uv_ok_i | input | 1 | Supply above the upper lockout threshold |
| out_a | output | 1 | Drive output A (polarity set by IDLE_HIGH) |
| out_b | output | 1 | Drive output B (polarity set by IDLE_HIGH) |

## Verification
The sync restart and the blanking interval can meet in the same cycle: a sync edge may land only a count or two after a natural wrap. The bench provokes this by pulsing sync every PERIOD+2 clocks. Each natural wrap then flips the steering, and the sync edge falls into blanking and must leave the steering alone. The bench judges the result by the split of active cycles between A and B over a window of several periods: an equal split passes, while a one-sided split shows a double toggle. Shutdown and pulse termination can also coincide, and a one-clock shutdown fired mid-pulse must leave that output dark until the next restart.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
   // Which push-pull leg owns the current period.
   typedef enum logic {
      SIDE_A = 1'b0,
      SIDE_B = 1'b1
   } side_e;
endpackage

// File: rtl/pwm_sync2.sv
module pwm_sync2 #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pwm_sync2: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_w
         $error("pwm_sync2: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] st_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
      end else begin
         st_q[0] <= d_i;
         for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
      end
   end

   assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/pwm_ramp.sv
module pwm_ramp #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] period_i,
   input  logic          sync_rise_i,
   output logic [CW-1:0] cnt_o,
   output logic          restart_o
);
   localparam logic [CW-1:0] ONE = CW'(1);

   logic [CW-1:0] cnt_q;
   logic          at_end;

   // A shrunk period is caught by >= so the ramp never runs away.
   assign at_end    = (cnt_q >= (period_i - ONE));
   assign restart_o = sync_rise_i | at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q <= '0;
      else if (restart_o) cnt_q <= '0;
      else                cnt_q <= cnt_q + ONE;
   end

   assign cnt_o = cnt_q;

   // R9: a synchronized sync edge puts the ramp back to zero
   p_sync_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sync_rise_i |=> (cnt_q == '0));
endmodule

// File: rtl/pwm_softstart.sv
module pwm_softstart #(
   parameter int CW      = 8,
   parameter int SS_DIV  = 2,
   parameter int SS_STEP = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lock_i,
   input  logic          shdn_i,
   input  logic          tick_i,
   output logic [CW-1:0] level_o
);
   localparam int            DW       = (SS_DIV > 1) ? $clog2(SS_DIV) : 1;
   localparam logic [DW-1:0] DIV_LAST = DW'(SS_DIV - 1);
   localparam logic [CW:0]   FULL     = {1'b0, {CW{1'b1}}};
   localparam logic [CW:0]   STEP_W   = (CW+1)'(SS_STEP);

   generate
      if (SS_DIV < 1) begin : g_bad_div
         $error("pwm_softstart: SS_DIV must be at least 1");
      end
      if (SS_STEP < 1 || SS_STEP >= (1 << CW)) begin : g_bad_step
         $error("pwm_softstart: SS_STEP out of range");
      end
   endgenerate

   logic [CW-1:0] lvl_q;
   logic [DW-1:0] div_q;
   logic [CW:0]   sum;
   logic [CW-1:0] lvl_up;

   assign sum    = {1'b0, lvl_q} + STEP_W;
   assign lvl_up = (sum > FULL) ? FULL[CW-1:0] : sum[CW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= '0;
         div_q <= '0;
      end else if (lock_i) begin
         lvl_q <= '0;
         div_q <= '0;
      end else if (shdn_i) begin
         lvl_q <= (lvl_q == '0) ? '0 : lvl_q - CW'(1);
         div_q <= '0;
      end else if (tick_i) begin
         if (div_q == DIV_LAST) begin
            div_q <= '0;
            lvl_q <= lvl_up;
         end else begin
            div_q <= div_q + DW'(1);
         end
      end
   end

   assign level_o = lvl_q;

   // R7: lockout empties the soft-start level
   p_lock_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      lock_i |=> (lvl_q == '0));
   // R6: shutdown drains a non-empty level
   p_shdn_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (shdn_i && !lock_i && lvl_q != '0) |=> (lvl_q < $past(lvl_q)));
   // R6: the level only moves on a period restart
   p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !shdn_i && !lock_i) |=> $stable(lvl_q));
endmodule

// File: rtl/pwm_uvlo.sv
module pwm_uvlo (
   input  logic clk,
   input  logic rst_n,
   input  logic uv_low_i,
   input  logic uv_ok_i,
   output logic lock_o
);
   logic lock_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        lock_q <= 1'b1;
      else if (uv_low_i) lock_q <= 1'b1;
      else if (uv_ok_i)  lock_q <= 1'b0;
   end

   assign lock_o = lock_q;

   // R7: the low flag always enters lockout
   p_uv_enter_r7: assert property (@(posedge clk) disable iff (!rst_n)
      uv_low_i |=> lock_q);
   // R7: inside the hysteresis band the state is held
   p_uv_band_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!uv_low_i && !uv_ok_i) |=> $stable(lock_q));
endmodule

// File: rtl/pwm_pushpull.sv
module pwm_pushpull
   import pwm_pkg::*;
#(
   parameter int CW        = 8,
   parameter int SS_DIV    = 2,
   parameter int SS_STEP   = 8,
   parameter bit IDLE_HIGH = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] period_i,
   input  logic [CW-1:0] dead_i,
   input  logic [CW-1:0] duty_i,
   input  logic          sync_i,
   input  logic          shdn_i,
   input  logic          uv_low_i,
   input  logic          uv_ok_i,
   output logic          out_a,
   output logic          out_b
);
   generate
      if (CW < 3 || CW > 16) begin : g_bad_cw
         $error("pwm_pushpull: CW must lie in 3..16");
      end
   endgenerate

   logic [1:0]    raw_in, syn_out;
   logic          sync_s, shdn_s, sync_d, sync_rise;
   logic [CW-1:0] cnt, ss_lvl, eff;
   logic          restart, lock;
   logic          in_blank, past_end, term_q, drive, drv_a, drv_b, drv_any;
   side_e         steer_q;

   assign raw_in = {shdn_i, sync_i};

   pwm_sync2 #(.W(2), .STAGES(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(syn_out)
   );
   assign sync_s = syn_out[0];
   assign shdn_s = syn_out[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_d <= 1'b0;
      else        sync_d <= sync_s;
   end
   assign sync_rise = sync_s & ~sync_d;

   pwm_ramp #(.CW(CW)) u_ramp (
      .clk(clk), .rst_n(rst_n), .period_i(period_i),
      .sync_rise_i(sync_rise), .cnt_o(cnt), .restart_o(restart)
   );

   pwm_uvlo u_uvlo (
      .clk(clk), .rst_n(rst_n), .uv_low_i(uv_low_i),
      .uv_ok_i(uv_ok_i), .lock_o(lock)
   );

   pwm_softstart #(.CW(CW), .SS_DIV(SS_DIV), .SS_STEP(SS_STEP)) u_ss (
      .clk(clk), .rst_n(rst_n), .lock_i(lock), .shdn_i(shdn_s),
      .tick_i(restart), .level_o(ss_lvl)
   );

   assign eff      = (duty_i < ss_lvl) ? duty_i : ss_lvl;
   assign in_blank = (cnt < dead_i);
   assign past_end = (cnt >= eff);

   // Termination latch: set by any pulse-ending cause, cleared at restart.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      term_q <= 1'b0;
      else if (shdn_s || lock)         term_q <= 1'b1;
      else if (restart)                term_q <= 1'b0;
      else if (!in_blank && past_end)  term_q <= 1'b1;
   end

   // Steering: one flip per period; a restart inside blanking is not a new period.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   steer_q <= SIDE_A;
      else if (restart && !in_blank) steer_q <= (steer_q == SIDE_A) ? SIDE_B : SIDE_A;
   end

   assign drive   = !in_blank && !past_end && !term_q && !shdn_s && !lock;
   assign drv_a   = drive && (steer_q == SIDE_A);
   assign drv_b   = drive && (steer_q == SIDE_B);
   assign drv_any = drv_a | drv_b;

   generate
      if (IDLE_HIGH) begin : g_idle_high
         assign out_a = ~drv_a;
         assign out_b = ~drv_b;
      end else begin : g_idle_low
         assign out_a = drv_a;
         assign out_b = drv_b;
      end
   endgenerate

   // R1: a pulse that stopped mid-period stays stopped
   p_latch_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(drv_any) && !drv_any && !restart && cnt != '0 && $stable(dead_i))
      |=> !drv_any);
   // R3: the count after a restart is blanked whenever DEAD is non-zero
   p_blank_after_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (dead_i == '0 || !drv_any));
   // R5: a synchronized shutdown keeps both legs dark on the next cycle
   p_shdn_dark_r5: assert property (@(posedge clk) disable iff (!rst_n)
      shdn_s |=> !drv_any);
   // R6: no leg drives beyond the soft-start level
   p_under_ss_r6: assert property (@(posedge clk) disable iff (!rst_n)
      drv_any |-> (cnt < ss_lvl));
endmodule

// File: tb/tb_pwm_pushpull.sv
`timescale 1ns/1ps
module tb_pwm_pushpull;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [CW-1:0] period_i, dead_i, duty_i;
   logic          sync_i, shdn_i, uv_low_i, uv_ok_i;
   logic          out_a, out_b, inv_a, inv_b;

   always #2 clk = ~clk;

   pwm_pushpull #(.CW(CW), .SS_DIV(1), .SS_STEP(16), .IDLE_HIGH(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .period_i(period_i), .dead_i(dead_i),
      .duty_i(duty_i), .sync_i(sync_i), .shdn_i(shdn_i),
      .uv_low_i(uv_low_i), .uv_ok_i(uv_ok_i), .out_a(out_a), .out_b(out_b)
   );

   pwm_pushpull #(.CW(CW), .SS_DIV(1), .SS_STEP(16), .IDLE_HIGH(1'b1)) dut_inv (
      .clk(clk), .rst_n(rst_n), .period_i(period_i), .dead_i(dead_i),
      .duty_i(duty_i), .sync_i(sync_i), .shdn_i(shdn_i),
      .uv_low_i(uv_low_i), .uv_ok_i(uv_ok_i), .out_a(inv_a), .out_b(inv_b)
   );

   int  n_chk = 0, n_bad = 0;
   int  m_a, m_b, m_inv, m_alt;
   bit  sync_on = 1'b0;
   int  sync_gap = 15;

   // {period, dead, duty, expected A cycles, expected B cycles} over 4 periods
   localparam int NV = 8;
   localparam int VEC [NV][5] = '{
      '{20, 4,  12, 16, 16},
      '{20, 4,   4,  0,  0},
      '{20, 4,   2,  0,  0},
      '{20, 4, 255, 32, 32},
      '{32, 2, 255, 60, 60},
      '{16, 6,  10,  8,  8},
      '{10, 1,   5,  8,  8},
      '{20, 0,  10, 20, 20}
   };

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   // Count active cycles per leg over n clocks, sampled at falling edges.
   task automatic measure(input int n);
      bit pa, pb;
      int last;
      m_a = 0; m_b = 0; m_inv = 0; m_alt = 0; last = 0;
      pa = out_a; pb = out_b;
      for (int k = 0; k < n; k++) begin
         if (out_a) m_a++;
         if (out_b) m_b++;
         if (inv_a != ~out_a || inv_b != ~out_b) m_inv++;
         if (out_a && out_b) m_alt++;
         if (out_a && !pa) begin if (last == 1) m_alt++; last = 1; end
         if (out_b && !pb) begin if (last == 2) m_alt++; last = 2; end
         pa = out_a; pb = out_b;
         @(negedge clk);
      end
   endtask

   task automatic cfg(input int p, input int d, input int u);
      period_i = CW'(p); dead_i = CW'(d); duty_i = CW'(u);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(4 * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 1 expected 0");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; sync_i = 1'b0; shdn_i = 1'b0; uv_low_i = 1'b0; uv_ok_i = 1'b0;
      cfg(20, 4, 255);
      repeat (5) @(negedge clk);
      // R7 / R8: reset state is locked, outputs idle
      check("R7 reset out_a", int'(out_a), 0);
      check("R7 reset out_b", int'(out_b), 0);
      check("R8 reset inv_a idle high", int'(inv_a), 1);
      check("R8 reset inv_b idle high", int'(inv_b), 1);
      rst_n = 1'b1;
      measure(40);
      check("R7 locked after reset", m_a + m_b, 0);
      uv_ok_i = 1'b1; @(negedge clk); uv_ok_i = 1'b0;
      repeat (1500) @(negedge clk);

      // Table walk: R3 width, R4 zero and max duty, R2 alternation, R8 polarity
      for (int v = 0; v < NV; v++) begin
         cfg(VEC[v][0], VEC[v][1], VEC[v][2]);
         repeat (3 * VEC[v][0] + 4) @(negedge clk);
         measure(4 * VEC[v][0]);
         check($sformatf("R3/R4 vec%0d leg A", v), m_a, VEC[v][3]);
         check($sformatf("R3/R4 vec%0d leg B", v), m_b, VEC[v][4]);
         check($sformatf("R2 vec%0d alternation", v), m_alt, 0);
         check($sformatf("R8 vec%0d inverse", v), m_inv, 0);
      end

      // R1 / R5: one-clock shutdown mid-pulse on A, latch keeps A dark
      cfg(20, 4, 255);
      repeat (80) @(negedge clk);
      while (out_a) @(negedge clk);
      while (!out_a) @(negedge clk);
      m_a = 0; m_b = 0;
      for (int k = 0; k < 40; k++) begin
         if (out_a) m_a++;
         if (out_b) m_b++;
         if (k == 3) shdn_i = 1'b1;
         if (k == 4) shdn_i = 1'b0;
         @(negedge clk);
      end
      check("R1/R5 truncated A pulse", m_a, 5);
      check("R1 B pulse after truncation", m_b, 16);
      measure(40);
      check("R6 short shutdown keeps A width", m_a, 16);
      check("R6 short shutdown keeps B width", m_b, 16);

      // R5 / R6: long shutdown, then slow restart
      shdn_i = 1'b1;
      repeat (3) @(negedge clk);
      measure(300);
      check("R5 held shutdown dark", m_a + m_b, 0);
      shdn_i = 1'b0;
      measure(40);
      check("R6 narrow after long shutdown", int'(m_a + m_b < 32), 1);
      repeat (600) @(negedge clk);
      measure(40);
      check("R6 recovered A", m_a, 16);
      check("R6 recovered B", m_b, 16);

      // R7: lockout entry, hysteresis hold, exit
      uv_low_i = 1'b1; @(negedge clk); uv_low_i = 1'b0;
      repeat (2) @(negedge clk);
      measure(60);
      check("R7 band holds lockout", m_a + m_b, 0);
      check("R8 inverse during lockout", m_inv, 0);
      uv_ok_i = 1'b1; @(negedge clk); uv_ok_i = 1'b0;
      repeat (600) @(negedge clk);
      measure(40);
      check("R7 running after exit A", m_a, 16);
      check("R7 running after exit B", m_b, 16);

      // R9: sync every 15 clocks shortens the period to 15
      sync_gap = 15; sync_on = 1'b1;
      fork
         begin
            while (sync_on) begin
               sync_i = 1'b1; @(negedge clk); sync_i = 1'b0;
               repeat (sync_gap - 1) @(negedge clk);
            end
         end
      join_none
      repeat (90) @(negedge clk);
      measure(60);
      check("R9 fast sync A", m_a, 22);
      check("R9 fast sync B", m_b, 22);

      // R10: sync every 22 clocks lands in blanking after each wrap
      sync_gap = 22;
      repeat (132) @(negedge clk);
      measure(88);
      check("R10 blanking sync A", m_a, 32);
      check("R10 blanking sync B", m_b, 32);
      check("R10 blanking sync alternation", m_alt, 0);
      sync_on = 1'b0;
      repeat (30) @(negedge clk);

      finish_run();
   end
endmodule